// File: doc/BRIEF.md
# Masked scalar half-precision adder

This block adds the lowest IEEE binary16 element of two 128-bit vector operands and returns a vector result. The upper 112 bits of the result come from the first source. The low element is written, kept or cleared under a one-bit writemask. The result is zero-extended to a parameterised maximum vector length. The arithmetic is combinational. One output register holds the merged vector and the five exception flags, so a result appears one clock after its operands are presented.

The rounding direction is normally the global rounding-mode input. An instruction may override it with its own code, but only when its second source is a register. Subnormal operands are computed in full precision and are never flushed. Every flag condition is reported on `flags_o`. Trapping and exception masking are left to the surrounding logic.

Top module: `hp_scalar_add`

## Requirements
- R1: Bits 15:0 of each source are read as binary16 values. Their correctly rounded sum appears on `res_o[15:0]` on the clock edge after the operands are applied. The latency is one cycle.
- R2: `res_o[127:16]` equals `src1_i[127:16]` of the same operation, whatever the mask inputs are.
- R3: All bits of `res_o` above bit 127 are zero.
- R4: The rounding code is `rc_code_i` when both `rc_ovr_i` and `src2_reg_i` are 1, and `rc_glob_i` otherwise. The encoding is 0 nearest-even, 1 toward negative infinity, 2 toward positive infinity, 3 toward zero.
- R5: The sum is written when `mask_en_i` is 0 or when `mask_bit_i` is 1.
- R6: When the sum is not written, `res_o[15:0]` is 0x0000 if `zero_en_i` is 1 and equals `dest_old_i[15:0]` otherwise. In both cases `flags_o` is zero.
- R7: The bits of `flags_o` are: bit 0 invalid, bit 1 denormal operand, bit 2 overflow, bit 3 underflow, bit 4 precision (inexact).
- R8: A quiet NaN input is returned unchanged, and the first source takes priority when both inputs are NaN. A signalling NaN input is returned with fraction bit 9 set and raises invalid. Infinity minus infinity gives 0x7E00 and raises invalid.
- R9: An exact zero sum of two operands with opposite signs is +0, except when rounding toward negative infinity, where it is −0 (0x8000).
- R10: On overflow the result is infinity, or the largest finite magnitude 0x7BFF, chosen by the rounding direction. Overflow and precision are both set.
- R11: Subnormal operands take part in full precision. The denormal flag is set when either operand has a zero exponent and a non-zero fraction. Underflow is raised only for a tiny result that is also inexact, so it stays clear for an exact subnormal sum.
- R12: While `rst_ni` is low, `res_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src1_i | input | 128 | First source; the low element is an addend and the upper bits pass through |
| src2_i | input | 128 | Second source; only bits 15:0 are used |
| dest_old_i | input | 128 | Previous destination value; bits 15:0 are kept under merge masking |
| mask_bit_i | input | 1 | Writemask bit for the low element |
| mask_en_i | input | 1 | 1 when a writemask applies |
| zero_en_i | input | 1 | 1 selects zeroing, 0 selects merging, for a masked-off element |
| rc_ovr_i | input | 1 | Per-instruction rounding override requested |
| rc_code_i | input | 2 | Per-instruction rounding code |
| src2_reg_i | input | 1 | Second source is a register |
| rc_glob_i | input | 2 | Global rounding mode |
| res_o | output | MAX_VL | Registered result vector |
| flags_o | output | 5 | Registered exception flags |

## Verification
The arithmetic flags and the mask merge can act in the same cycle. The bench applies operands that would overflow or raise invalid while the mask bit is clear, in both merge and zeroing modes. It then checks that the low element is the old or zeroed value and that no flag leaks out. A second overlap is between the rounding-override gate and the rounding itself. A half-ulp tie is added with an override code that disagrees with the global mode. The bench checks which direction the result rounds when the second source is a register and when it is not.

// File: rtl/hp_add_pkg.sv
package hp_add_pkg;
  localparam int EXP_W  = 5;
  localparam int FRAC_W = 10;
  localparam int HP_W   = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int NFLAG  = 5;

  localparam int FLG_INV = 0;
  localparam int FLG_DEN = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_UNF = 3;
  localparam int FLG_PRE = 4;

  localparam logic [HP_W-1:0] QNAN_DEF = 16'h7E00;
  localparam logic [HP_W-1:0] MAX_FIN  = 16'h7BFF;
  localparam logic [HP_W-1:0] POS_INF  = 16'h7C00;

  typedef enum logic [1:0] {
    RM_RNE = 2'd0,
    RM_RDN = 2'd1,
    RM_RUP = 2'd2,
    RM_RTZ = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/hp_unpack.sv
module hp_unpack
  import hp_add_pkg::*;
(
  input  logic [HP_W-1:0]   val_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,   // effective exponent, 1 for subnormals
  output logic [MANT_W-1:0] mant_o,  // with hidden bit
  output logic              sub_o,
  output logic              inf_o,
  output logic              nan_o,
  output logic              snan_o
);
  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] fr;

  always_comb begin
    sign_o = val_i[HP_W-1];
    ef     = val_i[HP_W-2:FRAC_W];
    fr     = val_i[FRAC_W-1:0];
    exp_o  = (ef == '0) ? EXP_W'(1) : ef;
    mant_o = {ef != '0, fr};
    sub_o  = (ef == '0) && (fr != '0);
    inf_o  = (ef == EXP_W'(EXP_MAX)) && (fr == '0);
    nan_o  = (ef == EXP_W'(EXP_MAX)) && (fr != '0);
    snan_o = nan_o && !fr[FRAC_W-1];
  end
endmodule

// File: rtl/hp_add_core.sv
module hp_add_core
  import hp_add_pkg::*;
(
  input  logic [HP_W-1:0]  a_i,
  input  logic [HP_W-1:0]  b_i,
  input  rnd_mode_e        rm_i,
  output logic [HP_W-1:0]  sum_o,
  output logic [NFLAG-1:0] flags_o
);
  localparam int SUM_W = MANT_W + 4;      // carry + mantissa + guard/round/sticky
  localparam int SH_W  = MANT_W + 3 + 16; // alignment window

  logic sa, sb, suba, subb, infa, infb, nana, nanb, snana, snanb;
  logic [EXP_W-1:0]  ea, eb;
  logic [MANT_W-1:0] ma, mb;

  hp_unpack u_ua (.val_i(a_i), .sign_o(sa), .exp_o(ea), .mant_o(ma), .sub_o(suba),
                  .inf_o(infa), .nan_o(nana), .snan_o(snana));
  hp_unpack u_ub (.val_i(b_i), .sign_o(sb), .exp_o(eb), .mant_o(mb), .sub_o(subb),
                  .inf_o(infb), .nan_o(nanb), .snan_o(snanb));

  logic              swap, big_s, eff_sub, inexact, rnd_up, tiny, ovf;
  logic [EXP_W-1:0]  big_e, sml_e, dexp;
  logic [MANT_W-1:0] big_m, sml_m, mfin;
  logic [SH_W-1:0]   shv;
  logic [SUM_W-1:0]  xo, yo, rs;
  logic [SUM_W-2:0]  m14;
  logic [3:0]        lz;
  logic [6:0]        e_n, e_f, shl, lim;
  logic [MANT_W:0]   mr;
  logic [HP_W-1:0]   fin;

  always_comb begin
    swap  = b_i[HP_W-2:0] > a_i[HP_W-2:0];
    big_s = swap ? sb : sa;
    big_e = swap ? eb : ea;
    big_m = swap ? mb : ma;
    sml_e = swap ? ea : eb;
    sml_m = swap ? ma : mb;
    eff_sub = sa ^ sb;
    dexp  = big_e - sml_e;
    shv   = {sml_m, 3'b000, 16'h0000} >> dexp;
    xo    = {1'b0, big_m, 3'b000};
    yo    = {1'b0, shv[SH_W-1:17], |shv[16:0]};
    rs    = eff_sub ? (xo - yo) : (xo + yo);

    lz = 4'd14;
    for (int i = 0; i < SUM_W - 1; i++)
      if (rs[i]) lz = 4'(SUM_W - 2 - i);
    lim = {2'b00, big_e} - 7'd1;
    if (rs[SUM_W-1]) begin
      m14 = {rs[SUM_W-1:2], |rs[1:0]};
      e_n = {2'b00, big_e} + 7'd1;
    end else begin
      shl = ({3'b000, lz} < lim) ? {3'b000, lz} : lim;
      m14 = rs[SUM_W-2:0] << shl;
      e_n = {2'b00, big_e} - shl;
    end

    inexact = |m14[2:0];
    tiny    = !m14[SUM_W-2];
    unique case (rm_i)
      RM_RNE: rnd_up = m14[2] && (m14[1] || m14[0] || m14[3]);
      RM_RDN: rnd_up = inexact && big_s;
      RM_RUP: rnd_up = inexact && !big_s;
      default: rnd_up = 1'b0;
    endcase
    mr = {1'b0, m14[SUM_W-2:3]} + {{MANT_W{1'b0}}, rnd_up};
    if (mr[MANT_W]) begin
      mfin = mr[MANT_W:1];
      e_f  = e_n + 7'd1;
    end else begin
      mfin = mr[MANT_W-1:0];
      e_f  = e_n;
    end
    ovf = e_f >= 7'(EXP_MAX);
    fin = {big_s, (mfin[MANT_W-1] ? e_f[EXP_W-1:0] : {EXP_W{1'b0}}), mfin[FRAC_W-1:0]};

    flags_o = '0;
    flags_o[FLG_DEN] = suba || subb;
    if (nana || nanb) begin
      sum_o = nana ? (a_i | 16'h0200) : (b_i | 16'h0200);
      flags_o[FLG_INV] = snana || snanb;
    end else if (infa && infb && eff_sub) begin
      sum_o = QNAN_DEF;
      flags_o[FLG_INV] = 1'b1;
    end else if (infa || infb) begin
      sum_o = infa ? a_i : b_i;
    end else if (rs == '0) begin
      sum_o = {(eff_sub ? (rm_i == RM_RDN) : sa), {(HP_W-1){1'b0}}};
    end else if (ovf) begin
      flags_o[FLG_OVF] = 1'b1;
      flags_o[FLG_PRE] = 1'b1;
      if (rm_i == RM_RTZ || (rm_i == RM_RDN && !big_s) || (rm_i == RM_RUP && big_s))
        sum_o = {big_s, MAX_FIN[HP_W-2:0]};
      else
        sum_o = {big_s, POS_INF[HP_W-2:0]};
    end else begin
      sum_o = fin;
      flags_o[FLG_PRE] = inexact;
      flags_o[FLG_UNF] = tiny && inexact;
    end
  end
endmodule

// File: rtl/hp_scalar_add.sv
module hp_scalar_add
  import hp_add_pkg::*;
#(
  parameter int MAX_VL = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [127:0]      src1_i,
  input  logic [127:0]      src2_i,
  input  logic [127:0]      dest_old_i,
  input  logic              mask_bit_i,
  input  logic              mask_en_i,
  input  logic              zero_en_i,
  input  logic              rc_ovr_i,
  input  logic [1:0]        rc_code_i,
  input  logic              src2_reg_i,
  input  logic [1:0]        rc_glob_i,
  output logic [MAX_VL-1:0] res_o,
  output logic [NFLAG-1:0]  flags_o
);
  localparam int LANE_W = 128;
  localparam int PAD_W  = MAX_VL - LANE_W;

  rnd_mode_e        rm_sel;
  logic [HP_W-1:0]  sum, low;
  logic [NFLAG-1:0] core_flg, flg;
  logic             wr_en, primed_q;

  always_comb
    rm_sel = rnd_mode_e'((rc_ovr_i && src2_reg_i) ? rc_code_i : rc_glob_i);

  hp_add_core u_core (
    .a_i(src1_i[HP_W-1:0]), .b_i(src2_i[HP_W-1:0]), .rm_i(rm_sel),
    .sum_o(sum), .flags_o(core_flg)
  );

  always_comb begin
    wr_en = !mask_en_i || mask_bit_i;
    low   = wr_en ? sum : (zero_en_i ? '0 : dest_old_i[HP_W-1:0]);
    flg   = wr_en ? core_flg : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      flags_o  <= '0;
      primed_q <= 1'b0;
    end else begin
      res_o    <= {{PAD_W{1'b0}}, src1_i[LANE_W-1:HP_W], low};
      flags_o  <= flg;
      primed_q <= 1'b1;
    end
  end

  AST_UPPER_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> res_o[LANE_W-1:HP_W] == $past(src1_i[LANE_W-1:HP_W])); // R2
  AST_ZERO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(mask_en_i && !mask_bit_i && zero_en_i)) |->
      (res_o[HP_W-1:0] == '0 && flags_o == '0)); // R6
  AST_MERGE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(mask_en_i && !mask_bit_i && !zero_en_i)) |->
      (res_o[HP_W-1:0] == $past(dest_old_i[HP_W-1:0]) && flags_o == '0)); // R6
  AST_OVF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_OVF] |-> flags_o[FLG_PRE]); // R10
  AST_UNF_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FLG_UNF] |-> flags_o[FLG_PRE]); // R11

  if (PAD_W > 0) begin : g_pad_chk
    AST_WIDE_ZERO: assert property (@(posedge clk_i)
      res_o[MAX_VL-1:LANE_W] == '0); // R3
  end
endmodule

// File: tb/hp_scalar_add_test.sv
module hp_scalar_add_test;
  localparam int VL = 512;
  localparam logic [4:0] F_INV = 5'b00001, F_DEN = 5'b00010, F_OVF = 5'b00100,
                         F_UNF = 5'b01000, F_PRE = 5'b10000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [127:0] s1 = '0, s2 = '0, dold = '0;
  logic mbit = 1'b0, men = 1'b0, zen = 1'b0, ovr = 1'b0, s2reg = 1'b0;
  logic [1:0] rcode = 2'd0, rglob = 2'd0;
  logic [VL-1:0] res;
  logic [4:0] flg;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  hp_scalar_add #(.MAX_VL(VL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src1_i(s1), .src2_i(s2), .dest_old_i(dold),
    .mask_bit_i(mbit), .mask_en_i(men), .zero_en_i(zen), .rc_ovr_i(ovr),
    .rc_code_i(rcode), .src2_reg_i(s2reg), .rc_glob_i(rglob),
    .res_o(res), .flags_o(flg)
  );

  task automatic chk(input string tag, input logic [VL-1:0] got, input logic [VL-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got[127:0], exp[127:0]);
    end
  endtask

  // apply one operation, return after the output register has captured it
  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic [1:0] glob);
    @(negedge clk);
    s1 = {112'hA5A5_0F0F_1234_5678_9ABC_DEF0_1357, a};
    s2 = {112'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF, b};
    rglob = glob;
    @(posedge clk); #1;
  endtask

  task automatic op_chk(input string tag, input logic [15:0] a, input logic [15:0] b,
                        input logic [1:0] glob, input logic [15:0] exp_v, input logic [4:0] exp_f);
    op(a, b, glob);
    chk({tag, " value"}, VL'(res[15:0]), VL'(exp_v));
    chk({tag, " flags"}, VL'(flg), VL'(exp_f));
  endtask

  task automatic t_reset;
    #1;
    chk("R12 reset res", res, '0);
    chk("R12 reset flags", VL'(flg), '0);
  endtask

  task automatic t_basic;
    op_chk("R1 1+1", 16'h3C00, 16'h3C00, 2'd0, 16'h4000, 5'b0);
    op_chk("R1 1+0.5", 16'h3C00, 16'h3800, 2'd0, 16'h3E00, 5'b0);
    op_chk("R1 cancel", 16'h3C01, 16'hBC00, 2'd0, 16'h1400, 5'b0);
    op_chk("R1 max+1 inexact", 16'h7BFF, 16'h3C00, 2'd0, 16'h7BFF, F_PRE);
    chk("R2 upper pass", VL'(res[127:16]), VL'(112'hA5A5_0F0F_1234_5678_9ABC_DEF0_1357));
    chk("R3 wide zero", VL'(res[VL-1:128]), '0);
  endtask

  task automatic t_round;
    op_chk("R4 tie rne", 16'h3C00, 16'h1000, 2'd0, 16'h3C00, F_PRE);
    op_chk("R4 tie rup", 16'h3C00, 16'h1000, 2'd2, 16'h3C01, F_PRE);
    op_chk("R4 tie rtz", 16'h3C00, 16'h1000, 2'd3, 16'h3C00, F_PRE);
    op_chk("R4 neg rdn", 16'hBC00, 16'h9000, 2'd1, 16'hBC01, F_PRE);
    op_chk("R4 neg rup", 16'hBC00, 16'h9000, 2'd2, 16'hBC00, F_PRE);
    @(negedge clk); ovr = 1'b1; rcode = 2'd2; s2reg = 1'b1;
    op_chk("R4 override used", 16'h3C00, 16'h1000, 2'd0, 16'h3C01, F_PRE);
    @(negedge clk); s2reg = 1'b0;
    op_chk("R4 override gated", 16'h3C00, 16'h1000, 2'd0, 16'h3C00, F_PRE);
    @(negedge clk); ovr = 1'b0; s2reg = 1'b1;
    op_chk("R4 no override", 16'h3C00, 16'h1000, 2'd0, 16'h3C00, F_PRE);
    @(negedge clk); s2reg = 1'b0; rcode = 2'd0;
  endtask

  task automatic t_mask;
    @(negedge clk); dold = {112'h0, 16'hBEEF}; men = 1'b1; mbit = 1'b1;
    op_chk("R5 mask bit set", 16'h3C00, 16'h3C00, 2'd0, 16'h4000, 5'b0);
    @(negedge clk); mbit = 1'b0; zen = 1'b0;
    op_chk("R6 merge", 16'h7BFF, 16'h7BFF, 2'd0, 16'hBEEF, 5'b0);
    chk("R2 upper masked", VL'(res[127:16]), VL'(112'hA5A5_0F0F_1234_5678_9ABC_DEF0_1357));
    @(negedge clk); zen = 1'b1;
    op_chk("R6 zeroing", 16'h7C00, 16'hFC00, 2'd0, 16'h0000, 5'b0);
    @(negedge clk); men = 1'b0;
    op_chk("R5 mask disabled", 16'h3C00, 16'h3800, 2'd0, 16'h3E00, 5'b0);
    @(negedge clk); zen = 1'b0;
  endtask

  task automatic t_special;
    op_chk("R8 inf-inf", 16'h7C00, 16'hFC00, 2'd0, 16'h7E00, F_INV);
    op_chk("R8 snan a", 16'h7C01, 16'h3C00, 2'd0, 16'h7E01, F_INV);
    op_chk("R8 qnan a", 16'h7E05, 16'h3C00, 2'd0, 16'h7E05, 5'b0);
    op_chk("R8 qnan b", 16'h3C00, 16'hFE10, 2'd0, 16'hFE10, 5'b0);
    op_chk("R8 both nan", 16'h7E01, 16'hFE02, 2'd0, 16'h7E01, 5'b0);
    op_chk("R7 inf+1", 16'h7C00, 16'h3C00, 2'd0, 16'h7C00, 5'b0);
    op_chk("R9 zero rne", 16'h3C00, 16'hBC00, 2'd0, 16'h0000, 5'b0);
    op_chk("R9 zero rdn", 16'h3C00, 16'hBC00, 2'd1, 16'h8000, 5'b0);
    op_chk("R9 zero rup", 16'h3C00, 16'hBC00, 2'd2, 16'h0000, 5'b0);
    op_chk("R10 ovf rne", 16'h7BFF, 16'h7BFF, 2'd0, 16'h7C00, F_OVF | F_PRE);
    op_chk("R10 ovf rtz", 16'h7BFF, 16'h7BFF, 2'd3, 16'h7BFF, F_OVF | F_PRE);
    op_chk("R10 neg ovf rup", 16'hFBFF, 16'hFBFF, 2'd2, 16'hFBFF, F_OVF | F_PRE);
    op_chk("R10 neg ovf rdn", 16'hFBFF, 16'hFBFF, 2'd1, 16'hFC00, F_OVF | F_PRE);
    op_chk("R11 sub+sub", 16'h0001, 16'h0001, 2'd0, 16'h0002, F_DEN);
    op_chk("R11 sub to normal", 16'h03FF, 16'h0001, 2'd0, 16'h0400, F_DEN);
    op_chk("R11 normal+sub", 16'h3C00, 16'h0001, 2'd2, 16'h3C01, F_DEN | F_PRE);
    if ((F_UNF & flg) != 0) chk("R11 no underflow", VL'(flg), '0);
  endtask

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_basic();
    t_round();
    t_mask();
    t_special();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule